// File: doc/BRIEF.md
# Conversion Start Arbiter and End-of-Sequence Interrupt Controller

This block sits between the trigger sources of a two-sequencer analog converter and the sequencers themselves. It accepts start requests from a software write, two timer event lines and an external pin. Each sequencer has its own set of masks for these sources. A sequencer keeps at most one pending request. The block issues a start pulse to that sequencer whenever the sequencer is not busy.

The two sequencers can work independently (dual mode) or as one chained sequencer (cascaded mode). In cascaded mode only the first sequencer can be started. The second timer line then reaches the first sequencer through a dedicated enable.

On the return path the block counts end-of-sequence (EOS) pulses from each sequencer. It sets a sticky interrupt flag either on every EOS or on every second EOS. Software clears the flag by pulsing a clear input.

Top module: `adc_soc_irq_ctl`

## Requirements
- R1: After reset, both pending flags, both start outputs and both interrupt flags are 0.
- R2: The first sequencer's request becomes pending one clock after any of these events: a software write with data 1; a rising edge of timer A while its mask enable is 1; a rising edge of the external pin while its enable is 1; or, in cascaded mode only, a rising edge of timer B while the cascaded enable is 1. A source whose enable is 0 has no effect.
- R3: The second sequencer's request becomes pending one clock after a software write with data 1 or a rising edge of timer B while its mask enable is 1. This applies in dual mode only; in cascaded mode both sources leave the second pending flag at 0.
- R4: A trigger line held high sets the pending flag only once, on its rising edge.
- R5: A start output is high exactly while its pending flag is 1 and its sequencer is not busy. The pending flag drops on the clock after a start, unless a new request arrives in that same cycle, in which case it stays 1.
- R6: A software write with data 0 clears that sequencer's pending flag on the next clock. The clear takes priority over any request arriving in the same cycle.
- R7: A sequencer reset pulse clears that sequencer's pending flag and its EOS parity count on the next clock.
- R8: In interrupt mode 0 (mode bit 0) with the enable set, each EOS pulse sets the interrupt flag on the next clock.
- R9: In interrupt mode 1, the flag is set only on the second, fourth and later even-numbered EOS pulses, counted since reset or since the last sequencer reset.
- R10: The interrupt flag stays 1 until a clear pulse. If a set and a clear occur in the same cycle, the set wins.
- R11: An EOS pulse with the interrupt enable at 0 does not set the flag, but it still advances the parity count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cascade | input | 1 | 1 = cascaded mode, 0 = dual mode |
| sw1_we | input | 1 | Software start write strobe, sequencer 1 |
| sw1_wdata | input | 1 | Software start write data, sequencer 1 |
| sw2_we | input | 1 | Software start write strobe, sequencer 2 |
| sw2_wdata | input | 1 | Software start write data, sequencer 2 |
| evta_trig | input | 1 | Timer A event line |
| evtb_trig | input | 1 | Timer B event line |
| ext_trig | input | 1 | External start pin |
| evta_en1 | input | 1 | Timer A may start sequencer 1 |
| ext_en1 | input | 1 | External pin may start sequencer 1 |
| evtb_casc_en | input | 1 | Timer B may start sequencer 1 (cascaded mode) |
| evtb_en2 | input | 1 | Timer B may start sequencer 2 (dual mode) |
| seq1_rst | input | 1 | Sequencer 1 reset pulse |
| seq2_rst | input | 1 | Sequencer 2 reset pulse |
| seq1_busy | input | 1 | Sequencer 1 is converting |
| seq2_busy | input | 1 | Sequencer 2 is converting |
| eos1 | input | 1 | End-of-sequence pulse, sequencer 1 |
| eos2 | input | 1 | End-of-sequence pulse, sequencer 2 |
| irq_en1 | input | 1 | Interrupt enable, sequencer 1 |
| irq_mode1 | input | 1 | 0 = every EOS, 1 = every second EOS, sequencer 1 |
| irq_en2 | input | 1 | Interrupt enable, sequencer 2 |
| irq_mode2 | input | 1 | 0 = every EOS, 1 = every second EOS, sequencer 2 |
| irq_clr1 | input | 1 | Clear interrupt flag 1 |
| irq_clr2 | input | 1 | Clear interrupt flag 2 |
| start1 | output | 1 | Start pulse to sequencer 1 |
| start2 | output | 1 | Start pulse to sequencer 2 |
| pend1 | output | 1 | Sequencer 1 request pending |
| pend2 | output | 1 | Sequencer 2 request pending |
| irq1 | output | 1 | Interrupt flag, sequencer 1 |
| irq2 | output | 1 | Interrupt flag, sequencer 2 |

## Verification
The hardest state to reach from the ports is the hidden EOS parity. It is visible only through which EOS pulse raises the flag in mode 1. The stimulus therefore counts EOS pulses across mode changes, enable changes and a sequencer reset. It then predicts whether the next pulse falls on an even count. Collisions in a single cycle are also staged on purpose, with the busy input held high so the pending flag stays visible: request against software clear, request against start, and set against interrupt clear.

// File: rtl/adc_soc_irq_ctl.sv
module adc_soc_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cascade,
  input  logic sw1_we,
  input  logic sw1_wdata,
  input  logic sw2_we,
  input  logic sw2_wdata,
  input  logic evta_trig,
  input  logic evtb_trig,
  input  logic ext_trig,
  input  logic evta_en1,
  input  logic ext_en1,
  input  logic evtb_casc_en,
  input  logic evtb_en2,
  input  logic seq1_rst,
  input  logic seq2_rst,
  input  logic seq1_busy,
  input  logic seq2_busy,
  input  logic eos1,
  input  logic eos2,
  input  logic irq_en1,
  input  logic irq_mode1,
  input  logic irq_en2,
  input  logic irq_mode2,
  input  logic irq_clr1,
  input  logic irq_clr2,
  output logic start1,
  output logic start2,
  output logic pend1,
  output logic pend2,
  output logic irq1,
  output logic irq2
);

  logic evta_q, evtb_q, ext_q;
  logic par1, par2;

  wire rise_a = evta_trig & ~evta_q;
  wire rise_b = evtb_trig & ~evtb_q;
  wire rise_x = ext_trig & ~ext_q;

  wire set1 = (sw1_we & sw1_wdata) | (evta_en1 & rise_a) | (ext_en1 & rise_x)
            | (cascade & evtb_casc_en & rise_b);
  wire set2 = ~cascade & ((sw2_we & sw2_wdata) | (evtb_en2 & rise_b));
  wire clr1 = seq1_rst | (sw1_we & ~sw1_wdata);
  wire clr2 = seq2_rst | (sw2_we & ~sw2_wdata);

  wire hit1 = eos1 & irq_en1 & (~irq_mode1 | par1);
  wire hit2 = eos2 & irq_en2 & (~irq_mode2 | par2);

  assign start1 = pend1 & ~seq1_busy;
  assign start2 = pend2 & ~seq2_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evta_q <= 1'b0;
      evtb_q <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      evta_q <= evta_trig;
      evtb_q <= evtb_trig;
      ext_q  <= ext_trig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend1 <= 1'b0;
      pend2 <= 1'b0;
    end else begin
      if (clr1)        pend1 <= 1'b0;
      else if (set1)   pend1 <= 1'b1;
      else if (start1) pend1 <= 1'b0;
      if (clr2)        pend2 <= 1'b0;
      else if (set2)   pend2 <= 1'b1;
      else if (start2) pend2 <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par1 <= 1'b0;
      par2 <= 1'b0;
      irq1 <= 1'b0;
      irq2 <= 1'b0;
    end else begin
      if (seq1_rst)  par1 <= 1'b0;
      else if (eos1) par1 <= ~par1;
      if (seq2_rst)  par2 <= 1'b0;
      else if (eos2) par2 <= ~par2;
      if (hit1)          irq1 <= 1'b1;
      else if (irq_clr1) irq1 <= 1'b0;
      if (hit2)          irq2 <= 1'b1;
      else if (irq_clr2) irq2 <= 1'b0;
    end
  end

  a_r6_wr0_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sw1_we && !sw1_wdata |=> !pend1);
  a_r7_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seq2_rst |=> !pend2);
  a_r3_casc_holds_seq2: assert property (@(posedge clk) disable iff (!rst_n)
    cascade && !pend2 |=> !pend2);
  a_r8_every_eos: assert property (@(posedge clk) disable iff (!rst_n)
    eos1 && irq_en1 && !irq_mode1 |=> irq1);
  a_r10_sticky1: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 && !irq_clr1 |=> irq1);
  a_r10_sticky2: assert property (@(posedge clk) disable iff (!rst_n)
    irq2 && !irq_clr2 |=> irq2);
  a_r11_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !irq2 && !irq_en2 |=> !irq2);

endmodule

// File: tb/adc_soc_irq_ctl_bench.sv
module adc_soc_irq_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cascade = 0, sw1_we = 0, sw1_wdata = 0, sw2_we = 0, sw2_wdata = 0;
  logic evta_trig = 0, evtb_trig = 0, ext_trig = 0;
  logic evta_en1 = 0, ext_en1 = 0, evtb_casc_en = 0, evtb_en2 = 0;
  logic seq1_rst = 0, seq2_rst = 0, seq1_busy = 0, seq2_busy = 0;
  logic eos1 = 0, eos2 = 0, irq_en1 = 0, irq_mode1 = 0, irq_en2 = 0, irq_mode2 = 0;
  logic irq_clr1 = 0, irq_clr2 = 0;
  logic start1, start2, pend1, pend2, irq1, irq2;

  always #2 clk = ~clk;

  adc_soc_irq_ctl u_adc_soc_irq_ctl (.*);

  typedef struct {
    string    tag;
    logic [5:0] v;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [5:0] got;
      e = q.pop_front();
      got = {pend1, pend2, start1, start2, irq1, irq2};
      checks++;
      if (got !== e.v) begin
        errors++;
        $display("FAIL %s: got pend1,pend2,start1,start2,irq1,irq2=%b expected %b",
                 e.tag, got, e.v);
      end
    end
  end

  task automatic tick(input string tag, input logic p1, p2, s1, s2, i1, i2);
    exp_t e;
    @(posedge clk);
    e.tag = tag;
    e.v = {p1, p2, s1, s2, i1, i2};
    q.push_back(e);
    @(negedge clk);
    #1;
    sw1_we = 0; sw2_we = 0; seq1_rst = 0; seq2_rst = 0;
    eos1 = 0; eos2 = 0; irq_clr1 = 0; irq_clr2 = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    tick("R1 reset state", 0,0,0,0,0,0);
    sw1_we = 1; sw1_wdata = 1;
    tick("R2 sw write sets seq1", 1,0,1,0,0,0);
    tick("R5 pending drops after start", 0,0,0,0,0,0);
    evta_trig = 1;
    tick("R2 masked timer A ignored", 0,0,0,0,0,0);
    evta_trig = 0; evta_en1 = 1;
    tick("R2 idle", 0,0,0,0,0,0);
    evta_trig = 1;
    tick("R2 timer A edge sets seq1", 1,0,1,0,0,0);
    tick("R4 held line no repeat", 0,0,0,0,0,0);
    tick("R4 held line still no repeat", 0,0,0,0,0,0);
    evta_trig = 0; seq1_busy = 1; ext_en1 = 1; ext_trig = 1;
    tick("R2 external pin sets seq1 busy", 1,0,0,0,0,0);
    ext_trig = 0; sw1_we = 1; sw1_wdata = 0;
    tick("R6 write 0 clears pending", 0,0,0,0,0,0);
    ext_trig = 1; sw1_we = 1; sw1_wdata = 0;
    tick("R6 clear beats same-cycle request", 0,0,0,0,0,0);
    ext_trig = 0; seq1_busy = 0;
    tick("R6 idle", 0,0,0,0,0,0);
    cascade = 1; evtb_casc_en = 1; evtb_en2 = 1; seq2_busy = 1; evtb_trig = 1;
    tick("R2 cascaded timer B starts seq1 R3 not seq2", 1,0,1,0,0,0);
    evtb_trig = 0; sw2_we = 1; sw2_wdata = 1;
    tick("R3 seq2 sw ignored in cascaded mode", 0,0,0,0,0,0);
    cascade = 0; evtb_trig = 1;
    tick("R3 dual timer B sets seq2 only", 0,1,0,0,0,0);
    evtb_trig = 0; seq2_rst = 1;
    tick("R7 seq reset clears pending", 0,0,0,0,0,0);
    seq2_busy = 0; sw2_we = 1; sw2_wdata = 1;
    tick("R3 sw write sets seq2", 0,1,0,1,0,0);
    tick("R5 seq2 pending drops", 0,0,0,0,0,0);
    sw1_we = 1; sw1_wdata = 1;
    tick("R5 request", 1,0,1,0,0,0);
    sw1_we = 1; sw1_wdata = 1;
    tick("R5 new request during start keeps pending", 1,0,1,0,0,0);
    tick("R5 then drops", 0,0,0,0,0,0);
    irq_en1 = 1; eos1 = 1;
    tick("R8 mode0 EOS sets flag", 0,0,0,0,1,0);
    irq_clr1 = 1;
    tick("R10 clear pulse", 0,0,0,0,0,0);
    eos1 = 1; irq_clr1 = 1;
    tick("R10 set beats clear", 0,0,0,0,1,0);
    tick("R10 flag sticky", 0,0,0,0,1,0);
    irq_clr1 = 1;
    tick("R10 clear", 0,0,0,0,0,0);
    irq_mode1 = 1; eos1 = 1;
    tick("R9 odd EOS no flag", 0,0,0,0,0,0);
    eos1 = 1;
    tick("R9 even EOS sets flag", 0,0,0,0,1,0);
    irq_clr1 = 1;
    tick("R9 clear", 0,0,0,0,0,0);
    eos1 = 1;
    tick("R9 odd EOS no flag again", 0,0,0,0,0,0);
    seq1_rst = 1;
    tick("R7 reset parity", 0,0,0,0,0,0);
    eos1 = 1;
    tick("R7 first EOS after reset no flag", 0,0,0,0,0,0);
    eos1 = 1;
    tick("R9 second EOS after reset flags", 0,0,0,0,1,0);
    irq_clr1 = 1;
    tick("R9 clear after reset case", 0,0,0,0,0,0);
    irq_mode2 = 1; eos2 = 1;
    tick("R11 disabled EOS no flag", 0,0,0,0,0,0);
    irq_en2 = 1; eos2 = 1;
    tick("R11 disabled EOS still counted", 0,0,0,0,0,1);
    irq_clr2 = 1;
    tick("R10 clear seq2 flag", 0,0,0,0,0,0);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule